// File: doc/BRIEF.md
# Flash Program/Erase Controller

This block sequences erase and program operations on an on-chip flash array model. Software sets up three keyed control registers (operation mode, timing-generator configuration, and status with lock bits) through a small register port. It then starts the armed operation by writing into flash address space through the CPU memory-write port. For an erase this is a dummy write of any value. For a program it is the data to be stored at that address.

Each operation runs for a fixed number of pulses on the `tick` input, which comes from an external timing generator. While the operation runs, the controller holds a level strobe for the operation kind toward the array, together with the latched address and data. When idle, the array is in read mode: no strobe is active and `tg_en` is low.

The controller applies the global lock, the information-segment-A lock, register key protection and the busy rule before it starts anything. An emergency-exit write aborts a running operation at once. Information memory is two 128-byte segments at `INFO_BASE`, with segment A the upper one. Main memory is made of 512-byte segments from `MAIN_BASE` to the top of the address space.

Top module: `flash_ctl`

## Requirements
- R1: After reset the mode register reads 0x9600, the status register reads 0x9650 (lock bit 4 and info-A lock bit 6 set), `busy` is low and no array strobe is active. Every register read returns 0x96 in bits 15:8. Register addresses are: 0 for mode, 1 for config, 2 for status.
- R2: A register write takes effect only when bits 15:8 equal 0xA5. A write with any other upper byte leaves every register unchanged and sets the key-violation flag (status bit 1). A keyed status write with bit 1 low clears that flag. The config register stores bits 7:0, which appear on `tg_cfg`.
- R3: With only the erase bit (mode bit 1) set and the lock clear, a flash write starts a segment erase. `arr_seg_erase` is held for ERASE_TICKS ticks, and `arr_addr` is the segment base: the address with its low 9 bits cleared in main memory, or its low 7 bits cleared in information memory.
- R4: With the mass bit (mode bit 2) set and the full-erase combination not present, a flash write raises `arr_main_erase` alone for ERASE_TICKS ticks.
- R5: With mode bits 3, 2 and 1 all set, a flash write raises `arr_main_erase` and also `arr_info_erase` for ERASE_TICKS ticks, provided the info-A lock was clear at the start.
- R6: With only the program bit (mode bit 6) set, a flash write raises `arr_prog` for PROG_TICKS ticks. During that time the write's address, data and byte flag are held on `arr_addr`, `arr_data` and `arr_byte`.
- R7: Status bit 0 and `tg_en` are high for the whole of an operation, which ends after exactly its tick count. At most one of `arr_seg_erase`, `arr_prog` and `arr_main_erase` is high at any time.
- R8: While the lock bit (status bit 4) is set, no flash write starts an operation.
- R9: While the info-A lock (status bit 6) is set, a segment erase or program aimed at information segment A (INFO_BASE+128 to INFO_BASE+255) does not start, and a full erase leaves `arr_info_erase` low. Information segment B is still allowed.
- R10: A keyed status write with bit 5 set drops `busy` and all strobes on the next clock and clears the mode register.
- R11: A flash write while busy starts nothing new and sets the access-violation flag (status bit 2). A keyed status write with bit 2 low clears that flag.
- R12: A write outside flash space, or a write when no mode bit is set, starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 config, 2 status |
| reg_wdata | input | 16 | Register write data, key in bits 15:8 |
| reg_rdata | output | 16 | Read data of the selected register |
| mem_wr | input | 1 | CPU write into memory space |
| mem_addr | input | ADDR_W | CPU write byte address |
| mem_wdata | input | 16 | CPU write data |
| mem_byte | input | 1 | CPU write is one byte |
| tick | input | 1 | Timing-generator pulse |
| tg_en | output | 1 | Timing generator and voltage generator enable |
| tg_cfg | output | 8 | Stored timing-generator configuration |
| busy | output | 1 | Operation in progress |
| arr_seg_erase | output | 1 | Segment erase strobe |
| arr_main_erase | output | 1 | Main-memory mass erase strobe |
| arr_info_erase | output | 1 | Information-memory erase strobe |
| arr_prog | output | 1 | Program strobe |
| arr_addr | output | ADDR_W | Latched operation address |
| arr_data | output | 16 | Latched program data |
| arr_byte | output | 1 | Latched byte flag |

## Verification
The hardest situations to reach are those that need an operation already running when a second event arrives. Examples are a flash write that lands while `busy` is high, and an emergency exit in the middle of an erase. The stimulus reaches them by starting a full 5000-tick erase and then issuing the conflicting write a few cycles later, checking the flags and the abort at the register port. The protection rules for segment A depend on both lock bits and the address range. They are reached by writing addresses just inside and just outside segment A, with each lock set and cleared in turn. Tick counts are measured against a tick input that is sometimes gated, so that duration is counted in ticks and not in clock cycles.

// File: rtl/flash_ctl_pkg.sv
// Shared constants and types of the flash program/erase controller.
// Assumes a 16-bit register bus with an 8-bit key in the upper byte.
package flash_ctl_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SEG,
        OP_MAIN,
        OP_FULL,
        OP_PROG
    } op_e;

    localparam logic [7:0] WR_KEY = 8'hA5;
    localparam logic [7:0] RD_KEY = 8'h96;

    // mode register bit positions
    localparam int MB_ERASE = 1;
    localparam int MB_MASS  = 2;
    localparam int MB_GMASS = 3;
    localparam int MB_PROG  = 6;
    localparam logic [7:0] MODE_MASK = 8'h4E;

    // status register bit positions
    localparam int SB_BUSY  = 0;
    localparam int SB_KEYV  = 1;
    localparam int SB_ACCV  = 2;
    localparam int SB_LOCK  = 4;
    localparam int SB_EMEX  = 5;
    localparam int SB_LOCKA = 6;

    localparam logic [1:0] RA_MODE = 2'd0;
    localparam logic [1:0] RA_CFG  = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;

endpackage

// File: rtl/flash_ctl_regs.sv
// Keyed control registers: mode, timing config, status/lock.
// Assumes one register access per cycle; reads are combinational.
module flash_ctl_regs
    import flash_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    input  logic        busy,
    input  logic        acc_set,
    output logic [15:0] reg_rdata,
    output logic [7:0]  mode_q,
    output logic [7:0]  cfg_q,
    output logic        lock_q,
    output logic        lock_a_q,
    output logic        keyv_q,
    output logic        accv_q,
    output logic        emex
);

    logic key_ok;
    logic [7:0] stat_lo;

    // key check and emergency-exit request decode
    always_comb begin
        key_ok = (reg_wdata[15:8] == WR_KEY);
        emex   = reg_wr && key_ok && (reg_addr == RA_STAT) && reg_wdata[SB_EMEX];
    end

    // register update with key protection and sticky violation flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            cfg_q    <= '0;
            lock_q   <= 1'b1;
            lock_a_q <= 1'b1;
            keyv_q   <= 1'b0;
            accv_q   <= 1'b0;
        end else begin
            if (acc_set) accv_q <= 1'b1;
            if (reg_wr) begin
                if (!key_ok) begin
                    keyv_q <= 1'b1;
                end else begin
                    case (reg_addr)
                        RA_MODE: mode_q <= reg_wdata[7:0] & MODE_MASK;
                        RA_CFG:  cfg_q  <= reg_wdata[7:0];
                        RA_STAT: begin
                            lock_q   <= reg_wdata[SB_LOCK];
                            lock_a_q <= reg_wdata[SB_LOCKA];
                            if (!reg_wdata[SB_KEYV]) keyv_q <= 1'b0;
                            if (!reg_wdata[SB_ACCV]) accv_q <= 1'b0;
                            if (reg_wdata[SB_EMEX])  mode_q <= '0;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // read multiplexer with the fixed read key in the upper byte
    always_comb begin
        stat_lo           = '0;
        stat_lo[SB_BUSY]  = busy;
        stat_lo[SB_KEYV]  = keyv_q;
        stat_lo[SB_ACCV]  = accv_q;
        stat_lo[SB_LOCK]  = lock_q;
        stat_lo[SB_LOCKA] = lock_a_q;
        case (reg_addr)
            RA_MODE: reg_rdata = {RD_KEY, mode_q};
            RA_CFG:  reg_rdata = {RD_KEY, cfg_q};
            RA_STAT: reg_rdata = {RD_KEY, stat_lo};
            default: reg_rdata = {RD_KEY, 8'h00};
        endcase
    end

endmodule

// File: rtl/flash_ctl_decode.sv
// Classifies a CPU write address into flash regions, derives the segment
// base and the requested operation from the mode bits.
// Assumes main memory runs from MAIN_BASE to the top of the address space.
module flash_ctl_decode
    import flash_ctl_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int INFO_BASE = 16'h1000,
    parameter int MAIN_BASE = 16'h8000,
    parameter int INFO_SEG  = 128,
    parameter int MAIN_SEG  = 512
) (
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mode_q,
    output logic              in_flash,
    output logic              in_info_a,
    output logic [ADDR_W-1:0] seg_base,
    output op_e               req_op
);

    localparam logic [ADDR_W-1:0] INFO_LO  = ADDR_W'(INFO_BASE);
    localparam logic [ADDR_W-1:0] INFO_A   = ADDR_W'(INFO_BASE + INFO_SEG);
    localparam logic [ADDR_W-1:0] INFO_TOP = ADDR_W'(INFO_BASE + 2*INFO_SEG - 1);
    localparam logic [ADDR_W-1:0] MAIN_LO  = ADDR_W'(MAIN_BASE);
    localparam logic [ADDR_W-1:0] INFO_MSK = ~ADDR_W'(INFO_SEG - 1);
    localparam logic [ADDR_W-1:0] MAIN_MSK = ~ADDR_W'(MAIN_SEG - 1);

    logic in_info;
    logic in_main;

    // region decode and segment base alignment
    always_comb begin
        in_info   = (mem_addr >= INFO_LO) && (mem_addr <= INFO_TOP);
        in_main   = (mem_addr >= MAIN_LO);
        in_flash  = in_info || in_main;
        in_info_a = in_info && (mem_addr >= INFO_A);
        seg_base  = in_info ? (mem_addr & INFO_MSK) : (mem_addr & MAIN_MSK);
    end

    // mode bits to operation, erase kinds ahead of program
    always_comb begin
        if (mode_q[MB_GMASS] && mode_q[MB_MASS] && mode_q[MB_ERASE]) req_op = OP_FULL;
        else if (mode_q[MB_MASS])  req_op = OP_MAIN;
        else if (mode_q[MB_ERASE]) req_op = OP_SEG;
        else if (mode_q[MB_PROG])  req_op = OP_PROG;
        else                       req_op = OP_NONE;
    end

endmodule

// File: rtl/flash_ctl_seq.sv
// Operation sequencer: applies the start rules, latches address and data,
// counts timing-generator ticks and drives the array strobes.
// Assumes ERASE_TICKS >= PROG_TICKS >= 1.
module flash_ctl_seq
    import flash_ctl_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int ERASE_TICKS = 5000,
    parameter int PROG_TICKS  = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [15:0]       mem_wdata,
    input  logic              mem_byte,
    input  logic              in_flash,
    input  logic              in_info_a,
    input  logic [ADDR_W-1:0] seg_base,
    input  op_e               req_op,
    input  logic              lock_q,
    input  logic              lock_a_q,
    input  logic              emex,
    input  logic              tick,
    output logic              busy,
    output logic              acc_set,
    output logic              arr_seg_erase,
    output logic              arr_main_erase,
    output logic              arr_info_erase,
    output logic              arr_prog,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [15:0]       arr_data,
    output logic              arr_byte
);

    localparam int CNT_W = $clog2(ERASE_TICKS + 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_TICKS - 1);
    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_TICKS - 1);

    op_e              op_q;
    logic [CNT_W-1:0] cnt_q;
    logic             info_ok_q;
    logic             a_blocked;
    logic             start;
    logic [CNT_W-1:0] last;

    // start qualification and busy-write violation
    always_comb begin
        busy      = (op_q != OP_NONE);
        a_blocked = in_info_a && lock_a_q && ((req_op == OP_SEG) || (req_op == OP_PROG));
        start     = mem_wr && in_flash && !busy && !lock_q && (req_op != OP_NONE) && !a_blocked;
        acc_set   = mem_wr && in_flash && busy;
        last      = (op_q == OP_PROG) ? PROG_LAST : ERASE_LAST;
    end

    // operation state, tick counter and latched array values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_NONE;
            cnt_q     <= '0;
            info_ok_q <= 1'b0;
            arr_addr  <= '0;
            arr_data  <= '0;
            arr_byte  <= 1'b0;
        end else if (emex) begin
            op_q <= OP_NONE;
        end else if (start) begin
            op_q      <= req_op;
            cnt_q     <= '0;
            info_ok_q <= !lock_a_q;
            arr_addr  <= (req_op == OP_SEG) ? seg_base : mem_addr;
            arr_data  <= mem_wdata;
            arr_byte  <= mem_byte;
        end else if (busy && tick) begin
            if (cnt_q == last) op_q <= OP_NONE;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    // level strobes toward the array
    always_comb begin
        arr_seg_erase  = (op_q == OP_SEG);
        arr_main_erase = (op_q == OP_MAIN) || (op_q == OP_FULL);
        arr_info_erase = (op_q == OP_FULL) && info_ok_q;
        arr_prog       = (op_q == OP_PROG);
    end

endmodule

// File: rtl/flash_ctl.sv
// Top of the flash program/erase controller: keyed registers, address
// decode and operation sequencer. Assumes a synchronous active-low reset.
module flash_ctl
    import flash_ctl_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int INFO_BASE   = 16'h1000,
    parameter int MAIN_BASE   = 16'h8000,
    parameter int INFO_SEG    = 128,
    parameter int MAIN_SEG    = 512,
    parameter int ERASE_TICKS = 5000,
    parameter int PROG_TICKS  = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [15:0]       mem_wdata,
    input  logic              mem_byte,
    input  logic              tick,
    output logic              tg_en,
    output logic [7:0]        tg_cfg,
    output logic              busy,
    output logic              arr_seg_erase,
    output logic              arr_main_erase,
    output logic              arr_info_erase,
    output logic              arr_prog,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [15:0]       arr_data,
    output logic              arr_byte
);

    logic [7:0]        mode_q;
    logic              lock_q;
    logic              lock_a_q;
    logic              keyv_q;
    logic              accv_q;
    logic              emex;
    logic              acc_set;
    logic              in_flash;
    logic              in_info_a;
    logic [ADDR_W-1:0] seg_base;
    op_e               req_op;

    flash_ctl_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .acc_set   (acc_set),
        .reg_rdata (reg_rdata),
        .mode_q    (mode_q),
        .cfg_q     (tg_cfg),
        .lock_q    (lock_q),
        .lock_a_q  (lock_a_q),
        .keyv_q    (keyv_q),
        .accv_q    (accv_q),
        .emex      (emex)
    );

    flash_ctl_decode #(
        .ADDR_W    (ADDR_W),
        .INFO_BASE (INFO_BASE),
        .MAIN_BASE (MAIN_BASE),
        .INFO_SEG  (INFO_SEG),
        .MAIN_SEG  (MAIN_SEG)
    ) i_decode (
        .mem_addr  (mem_addr),
        .mode_q    (mode_q),
        .in_flash  (in_flash),
        .in_info_a (in_info_a),
        .seg_base  (seg_base),
        .req_op    (req_op)
    );

    flash_ctl_seq #(
        .ADDR_W      (ADDR_W),
        .ERASE_TICKS (ERASE_TICKS),
        .PROG_TICKS  (PROG_TICKS)
    ) i_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .mem_wr         (mem_wr),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_byte       (mem_byte),
        .in_flash       (in_flash),
        .in_info_a      (in_info_a),
        .seg_base       (seg_base),
        .req_op         (req_op),
        .lock_q         (lock_q),
        .lock_a_q       (lock_a_q),
        .emex           (emex),
        .tick           (tick),
        .busy           (busy),
        .acc_set        (acc_set),
        .arr_seg_erase  (arr_seg_erase),
        .arr_main_erase (arr_main_erase),
        .arr_info_erase (arr_info_erase),
        .arr_prog       (arr_prog),
        .arr_addr       (arr_addr),
        .arr_data       (arr_data),
        .arr_byte       (arr_byte)
    );

    // generators run exactly while an operation is in progress
    always_comb tg_en = busy;

endmodule

// File: rtl/flash_ctl_chk.sv
// Checker for flash_ctl, bound into every instance of the top module.
// Assumes the key value 0xA5 and the status bit positions of the package.
module flash_ctl_chk
    import flash_ctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [15:0]       reg_wdata,
    input logic              mem_wr,
    input logic              in_flash,
    input logic              busy,
    input logic              lock_q,
    input logic              lock_a_q,
    input logic              keyv_q,
    input logic              accv_q,
    input logic              emex,
    input logic [7:0]        mode_q,
    input logic              arr_seg_erase,
    input logic              arr_main_erase,
    input logic              arr_info_erase,
    input logic              arr_prog,
    input logic [ADDR_W-1:0] arr_addr
);

    assert_bad_key_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[15:8] != WR_KEY) |=> keyv_q);

    assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_seg_erase, arr_prog, arr_main_erase}));

    assert_strobe_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (arr_seg_erase || arr_prog || arr_main_erase));

    assert_addr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(arr_addr));

    assert_lock_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mem_wr && lock_q) |=> !busy);

    assert_info_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_info_erase) |-> !$past(lock_a_q));

    assert_emex_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        emex |=> (!busy && mode_q == 8'h00));

    assert_busy_write_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_wr && in_flash && !reg_wr) |=> accv_q);

endmodule

bind flash_ctl flash_ctl_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr         (reg_wr),
    .reg_wdata      (reg_wdata),
    .mem_wr         (mem_wr),
    .in_flash       (in_flash),
    .busy           (busy),
    .lock_q         (lock_q),
    .lock_a_q       (lock_a_q),
    .keyv_q         (keyv_q),
    .accv_q         (accv_q),
    .emex           (emex),
    .mode_q         (mode_q),
    .arr_seg_erase  (arr_seg_erase),
    .arr_main_erase (arr_main_erase),
    .arr_info_erase (arr_info_erase),
    .arr_prog       (arr_prog),
    .arr_addr       (arr_addr)
);

// File: tb/test_flash_ctl.sv
// Scoreboard bench for flash_ctl: driver tasks push expected operations,
// a monitor pops one each time busy falls and compares what it saw.
module test_flash_ctl;

    localparam int ERASE_T = 5000;
    localparam int PROG_T  = 33;

    typedef struct {
        int          kind;   // 1 segment, 2 main, 4 program
        bit          info;
        logic [15:0] addr;
        logic [15:0] data;
        bit          bytef;
        int          ticks;  // -1: aborted, not compared
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        mem_wr = 1'b0;
    logic [15:0] mem_addr = 16'h0;
    logic [15:0] mem_wdata = 16'h0;
    logic        mem_byte = 1'b0;
    logic        tick = 1'b0;
    logic        tg_en;
    logic [7:0]  tg_cfg;
    logic        busy;
    logic        arr_seg_erase;
    logic        arr_main_erase;
    logic        arr_info_erase;
    logic        arr_prog;
    logic [15:0] arr_addr;
    logic [15:0] arr_data;
    logic        arr_byte;

    int   checks = 0;
    int   errors = 0;
    int   tick_div = 1;
    bit   done = 1'b0;
    exp_t exp_q[$];

    flash_ctl i_flash_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr         (reg_wr),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .mem_wr         (mem_wr),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_byte       (mem_byte),
        .tick           (tick),
        .tg_en          (tg_en),
        .tg_cfg         (tg_cfg),
        .busy           (busy),
        .arr_seg_erase  (arr_seg_erase),
        .arr_main_erase (arr_main_erase),
        .arr_info_erase (arr_info_erase),
        .arr_prog       (arr_prog),
        .arr_addr       (arr_addr),
        .arr_data       (arr_data),
        .arr_byte       (arr_byte)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_check(input string req, input logic [1:0] a, input logic [15:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, {16'h0, reg_rdata}, {16'h0, exp});
    endtask

    task automatic mem_write(input logic [15:0] a, input logic [15:0] d, input logic b);
        @(negedge clk);
        mem_wr = 1'b1; mem_addr = a; mem_wdata = d; mem_byte = b;
        @(negedge clk);
        mem_wr = 1'b0;
    endtask

    task automatic expect_op(input int kind, input bit info, input logic [15:0] a,
                             input logic [15:0] d, input bit b, input int t, input string req);
        exp_t e;
        e.kind = kind; e.info = info; e.addr = a; e.data = d;
        e.bytef = b; e.ticks = t; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // tick generator: every tick_div-th clock, changed right after the edge
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk);
            ph = (ph + 1) % tick_div;
            tick <= (ph == 0);
        end
    end

    // monitor: captures each operation and compares it on completion
    initial begin
        bit   was_busy = 1'b0;
        int   nt = 0;
        int   kind = 0;
        bit   info = 1'b0;
        logic [15:0] a = '0;
        logic [15:0] d = '0;
        bit   b = 1'b0;
        forever begin
            @(negedge clk);
            if (busy) begin
                if (!was_busy) begin
                    nt   = 0;
                    kind = arr_prog ? 4 : (arr_main_erase ? 2 : (arr_seg_erase ? 1 : 0));
                    info = arr_info_erase;
                    a = arr_addr; d = arr_data; b = arr_byte;
                    chk("R7 tg_en at start", {31'h0, tg_en}, 32'h1);
                end
                if (tick) nt++;
            end else if (was_busy) begin
                if (exp_q.size() == 0) begin
                    chk("R7 unexpected operation", 32'(kind), 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({e.req, " kind"}, 32'(kind), 32'(e.kind));
                    chk({e.req, " info erase"}, {31'h0, info}, {31'h0, e.info});
                    chk({e.req, " address"}, {16'h0, a}, {16'h0, e.addr});
                    if (e.kind == 4) begin
                        chk({e.req, " data"}, {16'h0, d}, {16'h0, e.data});
                        chk({e.req, " byte"}, {31'h0, b}, {31'h0, e.bytef});
                    end
                    if (e.ticks >= 0) chk({e.req, " R7 ticks"}, 32'(nt), 32'(e.ticks));
                end
            end
            was_busy = busy;
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_check("R1 mode reset", 2'd0, 16'h9600);
        reg_check("R1 status reset", 2'd2, 16'h9650);
        chk("R1 busy reset", {31'h0, busy}, 32'h0);
        chk("R1 strobes reset", {28'h0, arr_seg_erase, arr_main_erase, arr_info_erase, arr_prog}, 32'h0);

        // R2 key protection
        reg_write(2'd0, 16'h1242);
        reg_check("R2 bad key leaves mode", 2'd0, 16'h9600);
        reg_check("R2 bad key flag", 2'd2, 16'h9652);
        reg_write(2'd2, 16'hA500);
        reg_check("R2 flag cleared, locks open", 2'd2, 16'h9600);
        reg_write(2'd1, 16'hA542);
        reg_check("R2 config stored", 2'd1, 16'h9642);
        chk("R2 tg_cfg", {24'h0, tg_cfg}, 32'h42);

        // R8 lock blocks
        reg_write(2'd2, 16'hA510);
        reg_write(2'd0, 16'hA502);
        mem_write(16'h8234, 16'h0000, 1'b0);
        repeat (2) @(negedge clk);
        chk("R8 locked write starts nothing", {31'h0, busy}, 32'h0);

        // R3 main segment erase, R11 write while busy
        reg_write(2'd2, 16'hA500);
        expect_op(1, 1'b0, 16'h8200, 16'h0, 1'b0, ERASE_T, "R3 main segment erase");
        mem_write(16'h8234, 16'h0000, 1'b0);
        chk("R7 busy after start", {31'h0, busy}, 32'h1);
        mem_write(16'h8300, 16'h1111, 1'b0);
        reg_check("R11 access flag while busy", 2'd2, 16'h9605);
        chk("R11 no new operation", {16'h0, arr_addr}, 32'h8200);
        wait_idle();
        reg_check("R7 busy cleared", 2'd2, 16'h9604);
        reg_write(2'd2, 16'hA500);
        reg_check("R11 access flag cleared", 2'd2, 16'h9600);

        // R3 info segment erase, 128-byte alignment
        expect_op(1, 1'b0, 16'h1000, 16'h0, 1'b0, ERASE_T, "R3 info segment erase");
        mem_write(16'h1013, 16'h0000, 1'b0);
        wait_idle();

        // R6 program with gated ticks
        tick_div = 3;
        reg_write(2'd0, 16'hA540);
        expect_op(4, 1'b0, 16'h8456, 16'hBEEF, 1'b0, PROG_T, "R6 word program");
        mem_write(16'h8456, 16'hBEEF, 1'b0);
        wait_idle();
        tick_div = 1;

        // R4 main mass erase
        reg_write(2'd0, 16'hA504);
        expect_op(2, 1'b0, 16'h8000, 16'h0, 1'b0, ERASE_T, "R4 main mass erase");
        mem_write(16'h8000, 16'h0000, 1'b0);
        wait_idle();

        // R5 full erase, info A lock clear
        reg_write(2'd0, 16'hA50E);
        expect_op(2, 1'b1, 16'h9000, 16'h0, 1'b0, ERASE_T, "R5 full erase");
        mem_write(16'h9000, 16'h0000, 1'b0);
        wait_idle();

        // R9 full erase with info A lock set keeps information memory
        reg_write(2'd2, 16'hA540);
        expect_op(2, 1'b0, 16'h9000, 16'h0, 1'b0, ERASE_T, "R9 full erase with info lock");
        mem_write(16'h9000, 16'h0000, 1'b0);
        wait_idle();

        // R9 info A program blocked, info B allowed
        reg_write(2'd0, 16'hA540);
        mem_write(16'h1090, 16'h00AA, 1'b1);
        repeat (2) @(negedge clk);
        chk("R9 info A program blocked", {31'h0, busy}, 32'h0);
        reg_write(2'd0, 16'hA502);
        mem_write(16'h10FF, 16'h0000, 1'b0);
        repeat (2) @(negedge clk);
        chk("R9 info A erase blocked", {31'h0, busy}, 32'h0);
        reg_write(2'd0, 16'hA540);
        expect_op(4, 1'b0, 16'h107F, 16'h005A, 1'b1, PROG_T, "R9 info B byte program");
        mem_write(16'h107F, 16'h005A, 1'b1);
        wait_idle();

        // R12 no mode bit, and address outside flash
        reg_write(2'd0, 16'hA500);
        mem_write(16'h8000, 16'h1234, 1'b0);
        repeat (2) @(negedge clk);
        chk("R12 no mode bit", {31'h0, busy}, 32'h0);
        reg_write(2'd0, 16'hA540);
        mem_write(16'h0200, 16'h1234, 1'b0);
        repeat (2) @(negedge clk);
        chk("R12 outside flash", {31'h0, busy}, 32'h0);
        reg_check("R12 no access flag", 2'd2, 16'h9640);

        // R10 emergency exit during an erase
        reg_write(2'd0, 16'hA502);
        reg_write(2'd2, 16'hA500);
        expect_op(1, 1'b0, 16'h8000, 16'h0, 1'b0, -1, "R10 aborted erase");
        mem_write(16'h8010, 16'h0000, 1'b0);
        repeat (10) @(negedge clk);
        chk("R10 running before exit", {31'h0, busy}, 32'h1);
        reg_write(2'd2, 16'hA520);
        chk("R10 busy dropped", {31'h0, busy}, 32'h0);
        chk("R10 strobes dropped", {28'h0, arr_seg_erase, arr_main_erase, arr_info_erase, arr_prog}, 32'h0);
        reg_check("R10 mode cleared", 2'd0, 16'h9600);
        repeat (3) @(negedge clk);
        chk("R7 scoreboard drained", 32'(exp_q.size()), 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule